// File: doc/BRIEF.md
# SPI Serial Byte Memory

This block is an SPI slave in front of a byte-wide storage array. A host selects it by pulling the chip select low. The host then sends one command byte and, for memory commands, a 16-bit address and a stream of data bytes. Reads and writes complete at the speed of the serial clock, so the host never needs to poll for a busy state. A new transaction may begin as soon as chip select has gone high again. A write-enable latch guards the array: a write is stored only when the latch was set beforehand, and the latch drops again when the write transaction ends.

The pins are sampled in the system clock domain through a synchronizer, and every serial event is handled there. The serial clock high and low phases must each last at least six system clocks. `ADDR_W` sets the size of the array (2^ADDR_W bytes). The 8192-byte build uses `ADDR_W = 13`, and in that build the three top bits of the address field are ignored. The default of 11 keeps elaboration small.

Controller states:
- IDLE: chip select is high.
- CMD: the command byte is being shifted in.
- ADDR: the two address bytes are being shifted in.
- RDATA: read data is streaming out.
- WDATA: write data is streaming in.
- STATUS: the status byte is being returned.
- IGNORE: the transaction is dead until chip select rises.

Transitions:
- IDLE→CMD happens when chip select goes low.
- CMD→ADDR happens on a read or write command.
- CMD→STATUS happens on the status command.
- CMD→IGNORE happens on latch-set, latch-clear or an unknown code.
- ADDR→RDATA or ADDR→WDATA happens after the second address byte.
- Any state→IDLE happens when chip select goes high.

Top module: `spi_byte_mem`

## Requirements
- R1: Only the low ADDR_W bits of the 16-bit address field select a location. The higher bits, the top three when ADDR_W = 13, have no effect.
- R2: Command 0x03 (read), followed by the address, returns the addressed bytes on MISO, most significant bit first, starting at the falling SCK edge after the last address bit.
- R3: Command 0x02 (write) stores each complete data byte at the running address during the transfer. A read issued immediately after chip select rises returns the new byte.
- R4: A write issued while the write-enable latch is clear leaves the memory unchanged.
- R5: Command 0x06 sets the write-enable latch, and command 0x04 clears it. Command 0x05 returns a status byte whose bit 1 is the latch and whose other bits are 0.
- R6: The latch clears on reset and when chip select rises at the end of a write command.
- R7: The read and write address increments after every data byte and wraps from the top location to 0.
- R8: Only the first byte after a chip-select fall is decoded as a command. Later bytes in the same selection, including bytes after an unknown code, never act as commands.
- R9: SPI modes 0 and 3 both work. The SCK level at the chip-select fall selects the mode. In mode 3 the leading SCK fall is not a sample point, and input is always sampled on SCK rises.
- R10: MISO changes only after SCK falls. `miso_oe` is low whenever chip select is high and high during a selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High when miso should be driven onto the bus |

## Verification
Directed cases check the following:
- Status reads after reset and after each latch command.
- A write with the latch clear, read back to show the old byte survives.
- An address with high garbage bits, read back through a clean alias.
- A burst that crosses the top of the array.
- Command-like bytes sent after a first command in the same selection.

Random traffic then mixes every command, in both clock modes, at random addresses and burst lengths. Each read is compared against a bench model that honours the latch. This separates errors in latch gating, address masking, increment and wrap, and mode handling. A hold check on MISO during SCK high shows that output changes happen only on falling edges.

// File: rtl/spi_byte_mem_pkg.sv
package spi_byte_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_STATUS,
        ST_IGNORE
    } fsm_t;

    localparam int BYTE_W       = 8;
    localparam int ADDR_FIELD_W = 16;

    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;

endpackage

// File: rtl/spi_byte_mem_sync.sv
module spi_byte_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_lvl,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;
    // pin order inside each stage: {sck, cs_n, mosi}
    localparam logic [2:0] IDLE_PINS = 3'b010;

    logic [2:0] stg [STAGES];
    logic       sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_PINS;
            sck_prev <= 1'b0;
        end else begin
            stg[0] <= {sck, cs_n, mosi};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            sck_prev <= stg[LAST][2];
        end
    end

    always_comb begin
        sck_lvl   = stg[LAST][2];
        cs_active = !stg[LAST][1];
        mosi_s    = stg[LAST][0];
        sck_rise  = stg[LAST][2] && !sck_prev;
        sck_fall  = !stg[LAST][2] && sck_prev;
    end

endmodule

// File: rtl/spi_byte_mem_array.sv
module spi_byte_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/spi_byte_mem_ctrl.sv
module spi_byte_mem_ctrl
    import spi_byte_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_active,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              wel,
    output fsm_t              state
);
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    fsm_t                  state_q, state_d;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0]     in_sh;
    logic [BYTE_W-1:0]     addr_hi;
    logic                  addr_second;
    logic [ADDR_W-1:0]     ptr;
    logic                  is_write;
    logic [BYTE_W-1:0]     out_sh;
    logic                  miso_q;
    logic                  load_pend;
    logic                  mode3;
    logic                  seen_rise;

    logic                  byte_done;
    logic [BYTE_W-1:0]     rx_byte;
    logic                  fall_ok;
    logic [BYTE_W-1:0]     status_byte;
    logic [ADDR_FIELD_W-1:0] addr_field;

    always_comb begin
        rx_byte     = {in_sh, mosi_s};
        byte_done   = cs_active && sck_rise && (bit_cnt == LAST_BIT);
        fall_ok     = cs_active && sck_fall && (seen_rise || !mode3);
        status_byte = {{(BYTE_W-2){1'b0}}, wel, 1'b0};
        addr_field  = {addr_hi, rx_byte};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        case (rx_byte)
                            OP_READ, OP_WRITE: state_d = ST_ADDR;
                            OP_RDSR:           state_d = ST_STATUS;
                            default:           state_d = ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (byte_done && addr_second)
                        state_d = is_write ? ST_WDATA : ST_RDATA;
                end
                ST_RDATA:  state_d = ST_RDATA;
                ST_WDATA:  state_d = ST_WDATA;
                ST_STATUS: state_d = ST_STATUS;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            in_sh       <= '0;
            addr_hi     <= '0;
            addr_second <= 1'b0;
            ptr         <= '0;
            is_write    <= 1'b0;
            out_sh      <= '0;
            miso_q      <= 1'b0;
            load_pend   <= 1'b0;
            mode3       <= 1'b0;
            seen_rise   <= 1'b0;
            wel         <= 1'b0;
        end else if (!cs_active) begin
            if (state_q != ST_IDLE && is_write) wel <= 1'b0;
            is_write    <= 1'b0;
            bit_cnt     <= '0;
            addr_second <= 1'b0;
            out_sh      <= '0;
            miso_q      <= 1'b0;
            load_pend   <= 1'b0;
            seen_rise   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) mode3 <= sck_lvl;
            if (sck_rise) begin
                in_sh     <= rx_byte[BYTE_W-2:0];
                bit_cnt   <= bit_cnt + 1'b1;
                seen_rise <= 1'b1;
            end
            if (byte_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        case (rx_byte)
                            OP_WREN:  wel      <= 1'b1;
                            OP_WRDI:  wel      <= 1'b0;
                            OP_WRITE: is_write <= 1'b1;
                            OP_RDSR:  out_sh   <= status_byte;
                            default:  ;
                        endcase
                    end
                    ST_ADDR: begin
                        if (!addr_second) begin
                            addr_hi     <= rx_byte;
                            addr_second <= 1'b1;
                        end else begin
                            ptr       <= addr_field[ADDR_W-1:0];
                            load_pend <= !is_write;
                        end
                    end
                    ST_RDATA:  load_pend <= 1'b1;
                    ST_WDATA:  ptr       <= ptr + 1'b1;
                    ST_STATUS: out_sh    <= status_byte;
                    ST_IDLE, ST_IGNORE: ;
                    default: ;
                endcase
            end
            if (load_pend) begin
                out_sh    <= rd_data;
                ptr       <= ptr + 1'b1;
                load_pend <= 1'b0;
            end
            if (fall_ok) begin
                miso_q <= out_sh[BYTE_W-1];
                out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        miso     = miso_q;
        miso_oe  = (state_q != ST_IDLE);
        mem_addr = ptr;
        wr_data  = rx_byte;
        mem_we   = (state_q == ST_WDATA) && byte_done && wel;
    end

endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem
    import spi_byte_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic              sck_lvl_w, sck_rise_w, sck_fall_w, cs_active_w, mosi_s_w;
    logic              mem_we_w, wel_w;
    logic [ADDR_W-1:0] ptr_w;
    logic [BYTE_W-1:0] wr_data_w, rd_data_w;
    fsm_t              state_w;

    spi_byte_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sck_lvl   (sck_lvl_w),
        .sck_rise  (sck_rise_w),
        .sck_fall  (sck_fall_w),
        .cs_active (cs_active_w),
        .mosi_s    (mosi_s_w)
    );

    spi_byte_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_lvl   (sck_lvl_w),
        .sck_rise  (sck_rise_w),
        .sck_fall  (sck_fall_w),
        .cs_active (cs_active_w),
        .mosi_s    (mosi_s_w),
        .rd_data   (rd_data_w),
        .mem_we    (mem_we_w),
        .mem_addr  (ptr_w),
        .wr_data   (wr_data_w),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .wel       (wel_w),
        .state     (state_w)
    );

    spi_byte_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (mem_we_w),
        .addr  (ptr_w),
        .wdata (wr_data_w),
        .rdata (rd_data_w)
    );

endmodule

// File: rtl/spi_byte_mem_chk.sv
module spi_byte_mem_chk
    import spi_byte_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_active,
    input fsm_t              state,
    input logic              wel,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input logic              miso_oe
);
    // R10
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !miso_oe);

    // R6
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && !cs_active) |=> !wel);

    // R6
    wel_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wel);

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R8
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_CMD) |=> state != ST_CMD);

endmodule

bind spi_byte_mem spi_byte_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active_w),
    .state     (state_w),
    .wel       (wel_w),
    .mem_we    (mem_we_w),
    .ptr       (ptr_w),
    .miso_oe   (miso_oe)
);

// File: tb/spi_byte_mem_test.sv
module spi_byte_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int ADDR_W     = 11;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int total = 0;
    int bad = 0;
    int hold_err = 0;
    bit done = 0;

    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    bit         wel_m = 0;
    logic [7:0] wbuf [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_mem #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    function automatic logic [ADDR_W-1:0] map_addr(input logic [15:0] f);
        return f[ADDR_W-1:0];
    endfunction

    function automatic logic [7:0] status_of(input bit w);
        return {6'b0, w, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_begin(input bit m3);
        @(negedge clk) sck = m3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        if (m3) sck = 1'b0;
    endtask

    task automatic cs_end(input bit m3);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (m3) sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF - 2) @(negedge clk);
            if (miso !== rx[i]) hold_err++;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic do_simple(input bit m3, input logic [7:0] op);
        logic [7:0] rx;
        cs_begin(m3);
        xbyte(op, rx);
        cs_end(m3);
        if (op == 8'h06) wel_m = 1;
        if (op == 8'h04) wel_m = 0;
    endtask

    task automatic do_rdsr(input bit m3, input string req);
        logic [7:0] rx;
        cs_begin(m3);
        xbyte(8'h05, rx);
        xbyte(8'h00, rx);
        check(rx === status_of(wel_m), req, rx, status_of(wel_m));
        xbyte(8'h00, rx);
        check(rx === status_of(wel_m), req, rx, status_of(wel_m));
        cs_end(m3);
    endtask

    task automatic do_write(input bit m3, input logic [15:0] f, input int n);
        logic [7:0] rx;
        logic [ADDR_W-1:0] a;
        cs_begin(m3);
        xbyte(8'h02, rx);
        xbyte(f[15:8], rx);
        xbyte(f[7:0], rx);
        a = map_addr(f);
        for (int k = 0; k < n; k++) begin
            xbyte(wbuf[k], rx);
            if (wel_m) begin
                model[a] = wbuf[k];
                known[a] = 1;
            end
            a = a + 1'b1;
        end
        cs_end(m3);
        wel_m = 0;
    endtask

    task automatic do_read(input bit m3, input logic [15:0] f, input int n, input string req);
        logic [7:0] rx;
        logic [ADDR_W-1:0] a;
        cs_begin(m3);
        xbyte(8'h03, rx);
        xbyte(f[15:8], rx);
        xbyte(f[7:0], rx);
        a = map_addr(f);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx);
            if (known[a]) check(rx === model[a], req, rx, model[a]);
            a = a + 1'b1;
        end
        cs_end(m3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [15:0] last_f;
        int unsigned seed;
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10 reset state: output disabled
        check(miso_oe === 1'b0, "R10 oe after reset", miso_oe, 0);
        // R6 latch clear after reset, R5 status format
        do_rdsr(0, "R6 status after reset");

        // R5 latch set and clear
        do_simple(0, 8'h06);
        do_rdsr(0, "R5 status after set");
        do_simple(1, 8'h04);
        do_rdsr(1, "R5 status after clear");

        // R3 write then immediate read
        do_simple(0, 8'h06);
        wbuf[0] = 8'h3C;
        do_write(0, 16'h0010, 1);
        do_read(0, 16'h0010, 1, "R3 read right after write");
        // R6 latch dropped by write end
        do_rdsr(0, "R6 status after write");
        // R4 write with latch clear has no effect
        wbuf[0] = 8'hA5;
        do_write(0, 16'h0010, 1);
        do_read(0, 16'h0010, 1, "R4 old byte survives");

        // R1 high address bits ignored
        do_simple(0, 8'h06);
        wbuf[0] = 8'h77;
        do_write(0, 16'hE123, 1);
        do_read(0, 16'h0123, 1, "R1 clean alias");
        do_read(1, 16'h5123, 1, "R1 other alias");

        // R7 wrap from top to 0
        do_simple(0, 8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(0, 16'h07FE, 3);
        do_read(0, 16'h07FF, 2, "R7 wrap read");
        do_read(1, 16'h0000, 1, "R7 wrapped write");

        // R8 later bytes are not commands
        do_simple(0, 8'h06);
        cs_begin(0);
        xbyte(8'h04, rx);
        xbyte(8'h06, rx);
        cs_end(0);
        wel_m = 0;
        do_rdsr(0, "R8 second byte not decoded");
        cs_begin(1);
        xbyte(8'hFF, rx);
        xbyte(8'h06, rx);
        cs_end(1);
        do_rdsr(1, "R8 after unknown code");

        // R9 write in mode 3, read in both modes
        do_simple(1, 8'h06);
        wbuf[0] = 8'h9A; wbuf[1] = 8'h5B;
        do_write(1, 16'h0200, 2);
        do_read(0, 16'h0200, 2, "R9 mode 0 read");
        do_read(1, 16'h0200, 2, "R9 mode 3 read");

        // R10 output enable during selection; R2 first read bit
        cs_begin(0);
        check(miso_oe === 1'b1, "R10 oe during select", miso_oe, 1);
        xbyte(8'h03, rx);
        xbyte(8'h02, rx);
        xbyte(8'h00, rx);
        xbyte(8'h00, rx);
        check(rx === 8'h9A, "R2 msb-first read", rx, 8'h9A);
        cs_end(0);
        check(miso_oe === 1'b0, "R10 oe after deselect", miso_oe, 0);

        // random phase: R2 R3 R4 R5 R7 R9
        seed = $urandom(32'h5EED1234);
        last_f = 16'h0040;
        for (int t = 0; t < 60; t++) begin
            int op;
            int n;
            bit m3;
            logic [15:0] f;
            op = int'($urandom % 5);
            m3 = 1'($urandom % 2);
            n  = int'($urandom % 4) + 1;
            f  = 16'($urandom);
            case (op)
                0: do_simple(m3, 8'h06);
                1: do_simple(m3, 8'h04);
                2: begin
                    for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
                    if ($urandom % 3 == 0) do_simple(m3, 8'h06);
                    do_write(m3, f, n);
                    last_f = f;
                end
                3: begin
                    if ($urandom % 2 == 0) f = last_f ^ 16'hF800;
                    do_read(m3, f, n, "R7 random read");
                end
                default: do_rdsr(m3, "R5 random status");
            endcase
        end

        // R10 MISO held while SCK high
        check(hold_err == 0, "R10 miso stable while sck high", hold_err, 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule